// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Grid

This block is a parameterised grid of ROWS × COLS multiply-accumulate cells that computes int8 × int8 matrix products with int32 accumulation. Each cell keeps one signed 8-bit weight resident. Activations enter on the west edge, one per row per cycle, and step one cell east per cycle. Running sums enter at the top of each column and step one cell south per cycle. The bottom of each column presents its raw int32 result. Row k of the activation input is delayed by k cycles inside the block, so a caller presents one whole activation vector per cycle. The results come out with a per-column stagger, and no de-skew is applied.

Weights travel down the same vertical path that carries the running sums. A per-column load flag marks them. While the flag of a column is high, every cell in that column takes its vertical input as its new weight, forwards that value south unchanged, and sends zero east. A column is filled in ROWS cycles. The value supplied first settles in the bottom cell and the value supplied last settles in the top cell. When the flag is low, the vertical input is an addend. The first one entering a column for a given activation row is the bias, and the cells below receive partial sums. Column j can therefore be refilled as soon as it has finished its previous tile. There is no separate load phase in which the whole grid stands drained.

Top module: `wsa_grid`

## Requirements
- R1: After a synchronous active-low reset, every cell register holds zero. All `sum_out` columns read zero while reset is held, and they stay zero afterwards while the inputs are zero.
- R2: If activation vector X[m] enters on `act_in` in cycle T+m, column j has been loaded with W[·][j], and bias b[j] is driven on `top_in[j]` in cycle T+m+j, then `sum_out[j]` during cycle T+m+ROWS+j equals b[j] + Σk X[m][k]·W[k][j]. The activations and weights are two's-complement int8, and the sum wraps modulo 2^32.
- R3: While `load_col[j]` is high, a value that enters `top_in[j]` in cycle c reaches `sum_out[j]` unchanged in cycle c+ROWS, provided the flag stays high through cycle c+ROWS−1.
- R4: While `load_col[j]` is high, every cell of column j sends zero east, so the columns to the east see zero activations and produce only their bias.
- R5: When `load_col[j]` is held high for exactly ROWS cycles, row k of column j ends up holding the low 8 bits of the value supplied in load cycle ROWS−1−k. The top row therefore keeps the value supplied last.
- R6: Row k's activation reaches column 0 k cycles after it is presented. A product of M activation rows therefore finishes within M+ROWS+COLS−1 cycles, with the result for row m and column j appearing in cycle T+m+ROWS+j.
- R7: A second tile whose column j loads during cycles T2+j−ROWS … T2+j−1 may start at T2 = T1+M+2·ROWS−1. The results of both tiles then match R2.
- R8: While `load_col[j]` is low, the weights of column j do not change, so a later tile streamed without a reload uses the same weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| act_in | input | ROWS×ACT_W | One signed activation per row, presented unskewed |
| top_in | input | COLS×SUM_W | Vertical input per column: bias when the flag is low, weight (sign-extended) when it is high |
| load_col | input | COLS | Per-column weight load flag |
| sum_out | output | COLS×SUM_W | Raw signed result at the bottom of each column, not de-skewed |

## Verification
The assertions assume that the load flag and the vertical input of a column are driven together, and that the loaded values are sign-extended int8 numbers. They also assume that tile timing is left to the caller: the checks cover cell state and neighbour wiring, not the correctness of a schedule. The stimulus keeps to this by holding each column's flag for exactly ROWS cycles, by staggering the loads and biases one cycle per column, and by driving zero activations and zero bias outside every tile window. Back-to-back tiles are spaced by exactly M+2·ROWS−1 cycles, so no column is reloaded while any of its cells still holds a live partial sum.

// File: rtl/wsa_pkg.sv
// Shared widths and element types for the systolic grid.
// Assumes the accumulator is at least twice the activation width.
package wsa_pkg;
    parameter int ACT_W = 8;
    parameter int SUM_W = 32;

    typedef logic signed [ACT_W-1:0] act_t;
    typedef logic signed [SUM_W-1:0] sum_t;
endpackage

// File: rtl/wsa_skew.sv
// Input skew: delays row k of the activation vector by k cycles, so that
// the grid's diagonal wavefront lines up. Row 0 passes straight through.
// Assumes a synchronous active-low reset; all delay stages clear to zero.
module wsa_skew #(
    parameter int ROWS = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [ROWS-1:0][wsa_pkg::ACT_W-1:0]   raw_i,
    output logic [ROWS-1:0][wsa_pkg::ACT_W-1:0]   skew_o
);
    localparam int AW = wsa_pkg::ACT_W;

    for (genvar k = 0; k < ROWS; k++) begin : g_row
        if (k == 0) begin : g_pass
            assign skew_o[k] = raw_i[k];
        end else begin : g_dly
            logic [AW-1:0] pipe [k];

            // Shift row k through a k-stage delay line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < k; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= raw_i[k];
                    for (int i = 1; i < k; i++) pipe[i] <= pipe[i-1];
                end
            end

            assign skew_o[k] = pipe[k-1];
        end
    end
endmodule

// File: rtl/wsa_cell.sv
// One multiply-accumulate cell. It holds a stationary signed weight.
// Flag low : forward the activation east; send sum_i + act_i*weight south.
// Flag high: take sum_i as the new weight, forward sum_i south unchanged,
//            and send zero east.
// Assumes that the loaded values fit in ACT_W bits (sign-extended).
module wsa_cell (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  wsa_pkg::act_t       act_i,
    input  wsa_pkg::sum_t       sum_i,
    output wsa_pkg::act_t       act_o,
    output wsa_pkg::sum_t       sum_o,
    output wsa_pkg::act_t       wt_o
);
    localparam int AW = wsa_pkg::ACT_W;
    localparam int SW = wsa_pkg::SUM_W;
    localparam int PW = 2 * AW;

    wsa_pkg::act_t          wt_q;
    wsa_pkg::act_t          act_q;
    wsa_pkg::sum_t          sum_q;
    logic signed [PW-1:0]   prod;
    wsa_pkg::sum_t          prod_ext;

    // Signed product of the passing activation and the resident weight.
    always_comb begin
        prod     = act_i * wt_q;
        prod_ext = SW'(prod);
    end

    // Update the weight, the east register and the south register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wt_q  <= '0;
            act_q <= '0;
            sum_q <= '0;
        end else if (load_i) begin
            wt_q  <= sum_i[AW-1:0];
            act_q <= '0;
            sum_q <= sum_i;
        end else begin
            act_q <= act_i;
            sum_q <= sum_i + prod_ext;
        end
    end

    assign act_o = act_q;
    assign sum_o = sum_q;
    assign wt_o  = wt_q;
endmodule

// File: rtl/wsa_grid.sv
// Weight-stationary ROWS x COLS systolic grid (top level).
// Activations are skewed internally and then move east. Sums and tagged
// weights move south. The raw bottom-row sums are the outputs.
// Assumes that the caller schedules the loads and biases per column
// (see the brief).
module wsa_grid #(
    parameter int ROWS = 4,
    parameter int COLS = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [ROWS-1:0][wsa_pkg::ACT_W-1:0]   act_in,
    input  logic [COLS-1:0][wsa_pkg::SUM_W-1:0]   top_in,
    input  logic [COLS-1:0]                       load_col,
    output logic [COLS-1:0][wsa_pkg::SUM_W-1:0]   sum_out
);
    localparam int AW = wsa_pkg::ACT_W;

    logic [ROWS-1:0][AW-1:0] row_act;
    wsa_pkg::act_t           east  [ROWS][COLS+1];
    wsa_pkg::sum_t           south [ROWS+1][COLS];
    wsa_pkg::act_t           wts   [ROWS][COLS];
    logic [ROWS-1:0]         unused_east;

    wsa_skew #(.ROWS(ROWS)) skew_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (act_in),
        .skew_o (row_act)
    );

    for (genvar k = 0; k < ROWS; k++) begin : g_west
        assign east[k][0]     = row_act[k];
        assign unused_east[k] = ^east[k][COLS];
    end

    for (genvar j = 0; j < COLS; j++) begin : g_edge
        assign south[0][j] = top_in[j];
        assign sum_out[j]  = south[ROWS][j];
    end

    for (genvar k = 0; k < ROWS; k++) begin : g_r
        for (genvar j = 0; j < COLS; j++) begin : g_c
            wsa_cell cell_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_i (load_col[j]),
                .act_i  (east[k][j]),
                .sum_i  (south[k][j]),
                .act_o  (east[k][j+1]),
                .sum_o  (south[k+1][j]),
                .wt_o   (wts[k][j])
            );

            // R4: a loading column passes only zeros east.
            a_r4_east_zero: assert property (@(posedge clk) disable iff (!rst_n)
                load_col[j] |=> east[k][j+1] == '0);

            // R8: a weight stays put while its column flag is low.
            a_r8_weight_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !load_col[j] |=> wts[k][j] == $past(wts[k][j]));

            // R3: a loading cell forwards its vertical input unchanged.
            a_r3_sum_pass: assert property (@(posedge clk) disable iff (!rst_n)
                load_col[j] |=> south[k+1][j] == $past(south[k][j]));

            // R5: weights are taken from the value arriving from above.
            a_r5_weight_take: assert property (@(posedge clk) disable iff (!rst_n)
                load_col[j] |=> wts[k][j] == $past(south[k][j][AW-1:0]));
        end
    end
endmodule

// File: tb/wsa_grid_tb.sv
module wsa_grid_tb_top;
    localparam int R      = 4;
    localparam int C      = 4;
    localparam int MX     = 6;
    localparam int CLK_PD = 10;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [R-1:0][7:0]     act_in;
    logic [C-1:0][31:0]    top_in;
    logic [C-1:0]          load_col;
    logic [C-1:0][31:0]    sum_out;

    int n_checks = 0;
    int n_fail   = 0;

    int xs [2][MX][R];
    int ws [2][R][C];
    int bs [2][C];

    always #(CLK_PD/2) clk = ~clk;

    wsa_grid #(.ROWS(R), .COLS(C)) dut_i (
        .clk(clk), .rst_n(rst_n), .act_in(act_in),
        .top_in(top_in), .load_col(load_col), .sum_out(sum_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        act_in   = '0;
        top_in   = '0;
        load_col = '0;
    endtask

    function automatic int ref_y(int tl, int m, int j, bit hold0);
        int acc = bs[tl][j];
        if (hold0) return acc;
        for (int k = 0; k < R; k++) acc += xs[tl][m][k] * ws[tl][k][j];
        return acc;
    endfunction

    // Generic schedule: n tiles of m rows, spaced by m+2R-1 cycles.
    task automatic run_tiles(input int n, input int m, input bit ld, input bit hold0,
                             input int unit_rows, input string tag);
        int ts [2];
        int t_end;
        ts[0] = R;
        ts[1] = R + m + 2*R - 1;
        t_end = ts[n-1] + m + R + C + 2;
        for (int t = 0; t <= t_end; t++) begin
            idle();
            for (int i = 0; i < n; i++) begin
                if (t - ts[i] >= 0 && t - ts[i] < m)
                    for (int k = 0; k < R; k++) act_in[k] = 8'(xs[i][t-ts[i]][k]);
                for (int j = 0; j < C; j++) begin
                    if (ld && t >= ts[i]+j-R && t < ts[i]+j) begin
                        load_col[j] = 1'b1;
                        top_in[j]   = 32'(ws[i][R-1-(t-(ts[i]+j-R))][j]);
                    end
                    if (t - ts[i] - j >= 0 && t - ts[i] - j < m)
                        top_in[j] = 32'(bs[i][j]);
                end
            end
            if (hold0) begin
                load_col[0] = 1'b1;
                top_in[0]   = '0;
            end
            // Outputs now reflect the edge that ended cycle t-1.
            for (int i = 0; i < n; i++) begin
                for (int j = 0; j < C; j++) begin
                    if (ld && t == ts[i] + j)   // R3: first weight fed reaches the bottom
                        chk($signed(sum_out[j]) == ws[i][R-1][j], "R3",
                            $signed(sum_out[j]), ws[i][R-1][j]);
                    for (int mm = 0; mm < m; mm++) begin
                        if (t == ts[i] + mm + R + j && !(hold0 && j == 0))
                            chk($signed(sum_out[j]) == ref_y(i, mm, j, hold0),
                                (mm < unit_rows) ? "R5" : tag,
                                $signed(sum_out[j]), ref_y(i, mm, j, hold0));
                    end
                end
            end
            @(negedge clk);
        end
        idle();
    endtask

    task automatic t_reset();
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int j = 0; j < C; j++)   // R1 during reset
            chk(sum_out[j] == '0, "R1", $signed(sum_out[j]), 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        for (int j = 0; j < C; j++)   // R1 after release
            chk(sum_out[j] == '0, "R1", $signed(sum_out[j]), 0);
    endtask

    task automatic t_single_tile();   // R2, R3, R5, R6
        for (int m = 0; m < MX; m++)
            for (int k = 0; k < R; k++)
                xs[0][m][k] = (m < R) ? ((m == k) ? 1 : 0) : ((m*7 + k*5) % 23) - 11;
        for (int k = 0; k < R; k++)
            for (int j = 0; j < C; j++) ws[0][k][j] = ((k*9 + j*4 + 3) % 31) - 15;
        for (int j = 0; j < C; j++) bs[0][j] = 100*j - 150;
        run_tiles(1, MX, 1'b1, 1'b0, R, "R2");
    endtask

    task automatic t_extremes();   // R2 with int8 limits and 32-bit wrap
        for (int m = 0; m < MX; m++)
            for (int k = 0; k < R; k++) xs[0][m][k] = ((m + k) % 2 == 0) ? -128 : 127;
        for (int k = 0; k < R; k++)
            for (int j = 0; j < C; j++) ws[0][k][j] = ((k + j) % 3 == 0) ? -128 : 127;
        for (int j = 0; j < C; j++) bs[0][j] = 32'h7fff_ff00 - j;
        run_tiles(1, MX, 1'b1, 1'b0, 0, "R2");
    endtask

    task automatic t_reuse();   // R8: no reload, the previous weights remain
        for (int m = 0; m < MX; m++)
            for (int k = 0; k < R; k++) xs[0][m][k] = ((m*3 + k*11) % 17) - 8;
        for (int j = 0; j < C; j++) bs[0][j] = 7 - j;
        run_tiles(1, MX, 1'b0, 1'b0, 0, "R8");
    endtask

    task automatic t_single_row();   // R6: M=1 timing
        xs[0][0][0] = 5; xs[0][0][1] = -3; xs[0][0][2] = 9; xs[0][0][3] = -1;
        for (int k = 0; k < R; k++)
            for (int j = 0; j < C; j++) ws[0][k][j] = (k - j) * 6 + 1;
        for (int j = 0; j < C; j++) bs[0][j] = 1000 + j;
        run_tiles(1, 1, 1'b1, 1'b0, 0, "R6");
    endtask

    task automatic t_back_to_back();   // R7
        for (int i = 0; i < 2; i++) begin
            for (int m = 0; m < MX; m++)
                for (int k = 0; k < R; k++) xs[i][m][k] = ((m*5 + k*3 + i*7) % 19) - 9;
            for (int k = 0; k < R; k++)
                for (int j = 0; j < C; j++) ws[i][k][j] = ((k*7 + j*13 + i*29) % 41) - 20;
            for (int j = 0; j < C; j++) bs[i][j] = (i == 0) ? 11*j : -13*j - 4;
        end
        run_tiles(2, MX, 1'b1, 1'b0, 0, "R7");
    endtask

    task automatic t_load_blocks_east();   // R4: column 0 loading zeroes the east flow
        for (int m = 0; m < MX; m++)
            for (int k = 0; k < R; k++) xs[0][m][k] = 20 + m + k;
        for (int j = 0; j < C; j++) bs[0][j] = 300 + j;
        run_tiles(1, MX, 1'b0, 1'b1, 0, "R4");
    endtask

    initial begin
        rst_n = 1'b0;
        idle();
        @(negedge clk);
        t_reset();
        t_single_tile();
        t_extremes();
        t_reuse();
        t_single_row();
        t_back_to_back();
        t_load_blocks_east();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule